// File: doc/BRIEF.md
# Dual-Clock Resettable Line Delay Memory

This block is a line buffer of 8192 bytes (the depth is 2^AW words of DW bits) whose write side and read side each run on their own clock, with no assumed relation between the two. Each side has its own address counter. The counter steps once on every clock edge where that side's active-low enable is low. It is cleared by that side's own active-low counter reset. No flags are produced and the two addresses are never compared. The user sequences the two sides with the resets and enables, and that makes the block a delay line of programmable length, up to one full line.

Data moves as two plain streams. A byte is offered when the write enable is low, and it is always taken: there is no ready and no back-pressure. On the read side the enable requests the next word. The registered output is qualified by `rd_oe`, which stands for the drive state of a three-state bus: high means `rd_data` holds a freshly read word, and low means the bus would float. A written byte reaches the array one write-clock edge after it is captured. The user must therefore keep the write clock running for one more edge before that word is read.

Top module: `line_delay_mem`

## Requirements
- R1: On a write edge with `wr_rst_n`=1 and `wr_en_n`=0, the byte on `wr_data` is stored at the current write address and the write address advances by one.
- R2: On a write edge with `wr_rst_n`=1 and `wr_en_n`=1, no word is stored (the `wr_data` value is ignored) and the write address keeps its value.
- R3: On a write edge with `wr_rst_n`=0, the write address becomes zero. If `wr_en_n`=0 on that edge, its byte goes to word 0 and the next write goes to word 1.
- R4: On a read edge with `rd_rst_n`=1 and `rd_en_n`=0, `rd_data` takes the word at the current read address, `rd_oe` becomes 1, and the read address advances by one.
- R5: On a read edge with `rd_en_n`=1, `rd_oe` becomes 0 and the read address keeps its value. The next enabled read continues from the held address.
- R6: On a read edge with `rd_rst_n`=0, the read address becomes zero. If enabled, that same edge outputs word 0 and the next read is word 1. If disabled, the next enabled read outputs word 0.
- R7: A byte captured on write edge n lands in the array on write edge n+1, whatever the enables are on that edge. A read of that word before edge n+1 returns the word's previous content.
- R8: Both address counters wrap from 2^AW-1 (8191 by default) to 0 when no reset is applied, so a second line of writes overwrites the first in address order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write address counter clear, active low, synchronous to `wr_clk` |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | DW | Byte offered for writing |
| rd_clk | input | 1 | Read-side clock, unrelated to `wr_clk` |
| rd_rst_n | input | 1 | Read address counter clear, active low, synchronous to `rd_clk` |
| rd_en_n | input | 1 | Read enable, active low |
| rd_data | output | DW | Registered read word |
| rd_oe | output | 1 | High when `rd_data` carries a word read on the last read edge |

## Verification
The properties assume that each enable and reset is synchronous to its own side's clock. They are not checked until that side has seen its first counter reset, because the counters have no other initial state. The data checks also assume that no word is read before the write side has clocked past its commit edge. The stimulus keeps to this: inputs change on the falling edge of their own clock, each write phase ends with an idle write edge before the matching read phase starts, and the write clock is paused on purpose only to look at a read that comes before the commit.

// File: rtl/lmem_pkg.sv
package lmem_pkg;

  // Counter action chosen from the clear and enable pins of one side.
  typedef enum logic [1:0] {
    CTR_HOLD,
    CTR_STEP,
    CTR_ZERO,
    CTR_ONE
  } ctr_op_e;

  function automatic ctr_op_e ctr_decode(input logic clr_n, input logic act_n);
    if (!clr_n) return act_n ? CTR_ZERO : CTR_ONE;
    return act_n ? CTR_HOLD : CTR_STEP;
  endfunction

endpackage

// File: rtl/lmem_addr_ctr.sv
module lmem_addr_ctr #(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          clr_n,
  input  logic          act_n,
  output logic [AW-1:0] addr_now,
  output logic [AW-1:0] addr_q
);
  import lmem_pkg::*;

  ctr_op_e op;

  always_comb begin
    op = ctr_decode(clr_n, act_n);
    // A clearing edge services word 0 itself.
    addr_now = (op == CTR_ZERO || op == CTR_ONE) ? '0 : addr_q;
  end

  always_ff @(posedge clk) begin
    case (op)
      CTR_HOLD: addr_q <= addr_q;
      CTR_STEP: addr_q <= addr_q + 1'b1;
      CTR_ZERO: addr_q <= '0;
      CTR_ONE:  addr_q <= AW'(1);
      default:  addr_q <= addr_q;
    endcase
  end
endmodule

// File: rtl/lmem_wr_stage.sv
module lmem_wr_stage #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          act_n,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic          commit_en,
  output logic [AW-1:0] commit_addr,
  output logic [DW-1:0] commit_data
);
  // Captured byte waits here for one write edge before reaching the array.
  always_ff @(posedge clk) begin
    commit_en <= !act_n;
    if (!act_n) begin
      commit_addr <= addr_in;
      commit_data <= data_in;
    end
  end
endmodule

// File: rtl/lmem_dpram.sv
module lmem_dpram #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/line_delay_mem.sv
module line_delay_mem #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          wr_clk,
  input  logic          wr_rst_n,
  input  logic          wr_en_n,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  input  logic          rd_en_n,
  output logic [DW-1:0] rd_data,
  output logic          rd_oe
);
  logic [AW-1:0] wr_addr_now, wr_addr_q;
  logic [AW-1:0] rd_addr_now, rd_addr_q;
  logic          cm_en;
  logic [AW-1:0] cm_addr;
  logic [DW-1:0] cm_data;

  lmem_addr_ctr #(.AW(AW)) u_wctr (
    .clk(wr_clk), .clr_n(wr_rst_n), .act_n(wr_en_n),
    .addr_now(wr_addr_now), .addr_q(wr_addr_q)
  );

  lmem_wr_stage #(.AW(AW), .DW(DW)) u_wstg (
    .clk(wr_clk), .act_n(wr_en_n), .addr_in(wr_addr_now), .data_in(wr_data),
    .commit_en(cm_en), .commit_addr(cm_addr), .commit_data(cm_data)
  );

  lmem_addr_ctr #(.AW(AW)) u_rctr (
    .clk(rd_clk), .clr_n(rd_rst_n), .act_n(rd_en_n),
    .addr_now(rd_addr_now), .addr_q(rd_addr_q)
  );

  lmem_dpram #(.AW(AW), .DW(DW)) u_ram (
    .wclk(wr_clk), .we(cm_en), .waddr(cm_addr), .wdata(cm_data),
    .rclk(rd_clk), .re(!rd_en_n), .raddr(rd_addr_now), .rdata(rd_data)
  );

  always_ff @(posedge rd_clk) begin
    rd_oe <= !rd_en_n;
  end
endmodule

// File: rtl/line_delay_mem_chk.sv
module line_delay_mem_chk #(
  parameter int AW = 13
) (
  input logic          wr_clk,
  input logic          wr_rst_n,
  input logic          wr_en_n,
  input logic [AW-1:0] wr_addr,
  input logic          rd_clk,
  input logic          rd_rst_n,
  input logic          rd_en_n,
  input logic [AW-1:0] rd_addr,
  input logic          rd_oe
);
  logic wr_seen = 1'b0;
  logic rd_seen = 1'b0;

  always_ff @(posedge wr_clk) if (!wr_rst_n) wr_seen <= 1'b1;
  always_ff @(posedge rd_clk) if (!rd_rst_n) rd_seen <= 1'b1;

  p_wr_step_r1: assert property (@(posedge wr_clk) disable iff (!wr_seen)
    (wr_rst_n && !wr_en_n) |=> wr_addr == AW'($past(wr_addr) + 1'b1));
  p_wr_hold_r2: assert property (@(posedge wr_clk) disable iff (!wr_seen)
    (wr_rst_n && wr_en_n) |=> $stable(wr_addr));
  p_wr_clear_r3: assert property (@(posedge wr_clk) disable iff (!wr_seen)
    !wr_rst_n |=> wr_addr == AW'($past(!wr_en_n)));
  p_wr_wrap_r8: assert property (@(posedge wr_clk) disable iff (!wr_seen)
    (wr_rst_n && !wr_en_n && wr_addr == {AW{1'b1}}) |=> wr_addr == '0);

  p_rd_step_r4: assert property (@(posedge rd_clk) disable iff (!rd_seen)
    (rd_rst_n && !rd_en_n) |=> rd_addr == AW'($past(rd_addr) + 1'b1));
  p_rd_drive_r4: assert property (@(posedge rd_clk) disable iff (!rd_seen)
    !rd_en_n |=> rd_oe);
  p_rd_float_r5: assert property (@(posedge rd_clk) disable iff (!rd_seen)
    rd_en_n |=> !rd_oe);
  p_rd_hold_r5: assert property (@(posedge rd_clk) disable iff (!rd_seen)
    (rd_rst_n && rd_en_n) |=> $stable(rd_addr));
  p_rd_clear_r6: assert property (@(posedge rd_clk) disable iff (!rd_seen)
    !rd_rst_n |=> rd_addr == AW'($past(!rd_en_n)));
  p_rd_wrap_r8: assert property (@(posedge rd_clk) disable iff (!rd_seen)
    (rd_rst_n && !rd_en_n && rd_addr == {AW{1'b1}}) |=> rd_addr == '0);
endmodule

bind line_delay_mem line_delay_mem_chk #(.AW(AW)) chk_i (
  .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en_n(wr_en_n), .wr_addr(wr_addr_q),
  .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en_n(rd_en_n), .rd_addr(rd_addr_q),
  .rd_oe(rd_oe)
);

// File: tb/line_delay_mem_tb_top.sv
`timescale 1ns/1ps
module line_delay_mem_tb_top;
  localparam int AW = 13;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic wr_clk = 1'b0;
  logic rd_clk = 1'b0;
  logic wr_run = 1'b1;
  logic wr_rst_n, wr_en_n, rd_rst_n, rd_en_n, rd_oe;
  logic [DW-1:0] wr_data, rd_data;

  always #2 if (wr_run) wr_clk = ~wr_clk;   // 250 MHz write clock, can pause
  always #3 rd_clk = ~rd_clk;               // unrelated read clock

  line_delay_mem #(.AW(AW), .DW(DW)) dut_i (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en_n(wr_en_n), .wr_data(wr_data),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en_n(rd_en_n),
    .rd_data(rd_data), .rd_oe(rd_oe)
  );

  typedef struct {
    bit            oe;
    logic [DW-1:0] d;
    string         req;
  } exp_t;

  exp_t          exp_q[$];
  logic [DW-1:0] mdl [DEPTH];
  int            wptr = 0;
  int            rptr = 0;
  int            total = 0;
  int            bad = 0;
  bit            done = 1'b0;

  function automatic logic [DW-1:0] pat(input int i);
    return DW'(i * 13 + (i >>> 8));
  endfunction

  // Write driver: also keeps the expected array contents.
  task automatic wr_cycle(input bit rst, input bit en, input logic [DW-1:0] d);
    @(negedge wr_clk);
    wr_rst_n = !rst;
    wr_en_n  = !en;
    wr_data  = d;
    if (rst) wptr = 0;
    if (en) begin
      mdl[wptr] = d;
      wptr = (wptr + 1) % DEPTH;
    end
  endtask

  // Read driver: pushes the item the next read edge must produce.
  task automatic rd_push(input bit rst, input bit en, input logic [DW-1:0] d, input string req);
    exp_t e;
    @(negedge rd_clk);
    rd_rst_n = !rst;
    rd_en_n  = !en;
    e.oe  = en;
    e.d   = d;
    e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic rd_cycle(input bit rst, input bit en, input string req);
    logic [DW-1:0] d;
    if (rst) rptr = 0;
    d = mdl[rptr];
    if (en) rptr = (rptr + 1) % DEPTH;
    rd_push(rst, en, d, req);
  endtask

  task automatic drain();
    wait (exp_q.size() == 0);
    @(negedge rd_clk);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Monitor: compares each read edge against the scoreboard.
  always @(posedge rd_clk) begin
    exp_t e;
    #1;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      total++;
      if (e.oe) begin
        if (!(rd_oe === 1'b1 && rd_data === e.d)) begin
          bad++;
          $display("FAIL %s: rd_oe=%0b rd_data=%02h expected rd_oe=1 rd_data=%02h",
                   e.req, rd_oe, rd_data, e.d);
        end
      end else if (rd_oe !== 1'b0) begin
        bad++;
        $display("FAIL %s: rd_oe=%0b expected rd_oe=0", e.req, rd_oe);
      end
    end
  end

  initial begin
    #500000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run still active, expected completion");
      summary();
    end
  end

  initial begin
    logic [DW-1:0] stale;
    wr_rst_n = 1'b1; wr_en_n = 1'b1; wr_data = '0;
    rd_rst_n = 1'b1; rd_en_n = 1'b1;
    for (int i = 0; i < DEPTH; i++) mdl[i] = '0;

    // Reset state: counters cleared, output not driven (R5, R3, R6)
    wr_cycle(1, 0, 8'h00);
    wr_cycle(0, 0, 8'h00);
    rd_cycle(1, 0, "R5 reset idle");
    rd_cycle(0, 0, "R5 idle");
    drain();

    // Write with a disabled gap carrying junk data (R1, R2, R3)
    wr_cycle(1, 1, 8'h10);
    for (int i = 1; i < 10; i++) wr_cycle(0, 1, 8'h10 + DW'(i));
    for (int i = 0; i < 3; i++) wr_cycle(0, 0, 8'hEE);
    for (int i = 10; i < 20; i++) wr_cycle(0, 1, 8'h10 + DW'(i));
    wr_cycle(0, 0, 8'h00);

    // Read back with a disabled gap (R4, R5, R6)
    rd_cycle(1, 1, "R6 reset read");
    for (int i = 1; i < 10; i++) rd_cycle(0, 1, "R1 R4 sequence");
    rd_cycle(0, 0, "R5 gap");
    rd_cycle(0, 0, "R5 gap");
    for (int i = 10; i < 20; i++) rd_cycle(0, 1, "R2 R5 held address");
    rd_cycle(0, 0, "R5 idle");
    drain();

    // Mid-stream write reset overwrites the head only (R3)
    wr_cycle(1, 1, 8'hA0);
    wr_cycle(0, 1, 8'hA1);
    wr_cycle(0, 1, 8'hA2);
    wr_cycle(0, 0, 8'h00);
    rd_cycle(1, 1, "R3 word0");
    for (int i = 0; i < 3; i++) rd_cycle(0, 1, "R3 following");
    rd_cycle(0, 0, "R5 idle");
    drain();

    // Read reset while disabled (R6)
    rd_cycle(1, 0, "R6 clear idle");
    rd_cycle(0, 1, "R6 first after clear");
    rd_cycle(0, 1, "R6 second after clear");
    rd_cycle(0, 0, "R5 idle");
    drain();

    // Read before commit sees old content, after commit the new (R7)
    stale = mdl[0];
    wr_cycle(1, 1, 8'h5A);
    @(negedge wr_clk);
    wr_en_n = 1'b1;
    wr_rst_n = 1'b1;
    wr_run = 1'b0;
    rd_push(1, 1, stale, "R7 before commit");
    rptr = 1;
    rd_cycle(0, 0, "R5 idle");
    drain();
    wr_run = 1'b1;
    wr_cycle(0, 0, 8'h00);
    wr_cycle(0, 0, 8'h00);
    rd_cycle(1, 1, "R7 after commit");
    rd_cycle(0, 0, "R5 idle");
    drain();

    // Full line plus overlap: both counters wrap (R8)
    wr_cycle(1, 1, pat(0));
    for (int i = 1; i < DEPTH + 4; i++) wr_cycle(0, 1, pat(i));
    wr_cycle(0, 0, 8'h00);
    rd_cycle(1, 1, "R8 line start");
    for (int i = 1; i < DEPTH + 4; i++) rd_cycle(0, 1, "R8 wrap");
    rd_cycle(0, 0, "R5 idle");
    drain();

    done = 1'b1;
    summary();
  end
endmodule